// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Line Fill Buffer

This block is a read-only, direct-mapped instruction cache on a processor's local fetch bus. It stores 512 lines of four 32-bit words (8 KB). A fetch is looked up in the tag and word arrays and, in the same cycle, in a one-line fill buffer that holds the most recently missed line. A hit in either place returns the word combinationally in the cycle the fetch is presented.

On a miss in both places, the block issues a single-cycle request for a four-word burst from external memory. The burst begins with the missed word and wraps through the line. Each word becomes usable the moment it lands in the fill buffer. While the rest of the line streams in, the fetch bus stays free for other hits. Once the fourth word has arrived, the complete line is copied into the arrays.

A fetch that the system decodes as belonging to the tightly coupled SRAM is left to that SRAM: the cache gives no answer and starts no memory traffic. An invalidate-all input empties the cache.

Top module: `icache_top`

## Requirements
- R1: After reset, every line and every fill-buffer word is invalid, `mem_req` is low, and the first fetch of any address is a miss.
- R2: A fetch whose line is valid in the arrays with a matching tag, or whose word is valid in the fill buffer, raises `cache_ready` in the same cycle with the stored word on `fetch_rdata`. `cache_ready` is never high without `fetch_req`.
- R3: Address bits [3:2] select the word, bits [12:4] select the line and bits [31:13] form the tag. Two addresses with equal bits [12:4] and different tags evict each other.
- R4: A fetch that misses everywhere while no fill is outstanding causes `mem_req` to be high for exactly one cycle, in the next cycle. `mem_addr` is the fetch address with bits [1:0] cleared. Memory returns four words on `mem_rvalid`: first the requested word, then word offsets +1, +2 and +3 modulo 4.
- R5: A fetched word is served from the fill buffer as soon as its own beat has been captured, without waiting for the remaining beats.
- R6: While a fill is outstanding, fetches that hit the arrays are served in one cycle.
- R7: A miss presented while a fill is outstanding raises no new `mem_req` and stalls until the current line has been written, after which its own request is issued.
- R8: One cycle after the fourth beat, the line is written into the arrays. It keeps hitting after the fill buffer has moved on to another line.
- R9: While `sram_sel` is high, `cache_ready` stays low and no `mem_req` follows.
- R10: `flush` clears all line valid bits and fill-buffer valid bits, and nothing hits in the following cycle. An outstanding burst is still absorbed, but its words are neither served nor written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch strobe, held until served |
| fetch_addr | input | 32 | Fetch byte address |
| sram_sel | input | 1 | Address decoded to the local SRAM |
| flush | input | 1 | Invalidate all lines and the fill buffer |
| cache_ready | output | 1 | Fetch served by the cache this cycle |
| fetch_rdata | output | 32 | Fetched word, zero when not ready |
| mem_req | output | 1 | One-cycle line burst request |
| mem_addr | output | 32 | Word address of the missed fetch |
| mem_rvalid | input | 1 | Burst beat valid |
| mem_rdata | input | 32 | Burst beat data |

## Verification
The hardest situations to reach are those in which the fill buffer is only partly valid while the fetch bus is already moving on. These are an early-word hit, a hit to a different line during a fill, a second miss that must wait, and a flush in the middle of a burst. The bench reaches them with a memory model that has a fixed latency and returns the wrapped beats on known cycles. The bench changes the fetch address on exact cycles counted from the request, so that each check lands between two specific beats.

// File: rtl/icache_pkg.sv
`timescale 1ns/1ps
package icache_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 2;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/icache_tag_store.sv
`timescale 1ns/1ps
module icache_tag_store #(
    parameter int LINES = 512,
    parameter int TAG_W = 19,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_vld,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [TAG_W-1:0] tags [LINES];
    logic [LINES-1:0] vld_d, vld_q;

    always_comb begin
        vld_d = vld_q;
        if (clr_all) begin
            vld_d = '0;
        end else if (wr_en) begin
            vld_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) tags[wr_idx] <= wr_tag;
    end

    assign rd_tag = tags[rd_idx];
    assign rd_vld = vld_q[rd_idx];
endmodule

// File: rtl/icache_data_bank.sv
`timescale 1ns/1ps
module icache_data_bank #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/icache_top.sv
`timescale 1ns/1ps
module icache_top
    import icache_pkg::*;
#(
    parameter int LINES      = 512,
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              sram_sel,
    input  logic              flush,
    output logic              cache_ready,
    output logic [DATA_W-1:0] fetch_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFF_W    = $clog2(LINE_WORDS);
    localparam int IDX_W    = $clog2(LINES);
    localparam int LINE_LSB = BYTE_W + OFF_W;
    localparam int TAG_LSB  = LINE_LSB + IDX_W;
    localparam int TAG_W    = ADDR_W - TAG_LSB;
    localparam int LADDR_W  = ADDR_W - LINE_LSB;
    localparam int CNT_W    = OFF_W + 1;

    typedef struct packed {
        logic                                busy;
        logic                                kill;
        logic                                req;
        addr_t                               req_addr;
        logic [LADDR_W-1:0]                  fb_line;
        logic [LINE_WORDS-1:0]               fb_vld;
        logic [LINE_WORDS-1:0][DATA_W-1:0]   fb_data;
        logic [OFF_W-1:0]                    beat_off;
        logic [CNT_W-1:0]                    beats;
    } fill_state_t;

    fill_state_t st_d, st_q;

    // fetch address fields
    logic [LADDR_W-1:0] f_line;
    logic [OFF_W-1:0]   f_off;
    logic [IDX_W-1:0]   f_idx;
    logic [TAG_W-1:0]   f_tag;
    logic               unused_bits;

    assign f_line      = fetch_addr[ADDR_W-1:LINE_LSB];
    assign f_off       = fetch_addr[LINE_LSB-1:BYTE_W];
    assign f_idx       = fetch_addr[TAG_LSB-1:LINE_LSB];
    assign f_tag       = fetch_addr[ADDR_W-1:TAG_LSB];
    assign unused_bits = ^fetch_addr[BYTE_W-1:0];

    // array lookup
    logic [TAG_W-1:0]  arr_tag;
    logic              arr_vld;
    logic [DATA_W-1:0] bank_rd [LINE_WORDS];
    logic              fill_wr;

    icache_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) i_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (flush),
        .rd_idx  (f_idx),
        .rd_tag  (arr_tag),
        .rd_vld  (arr_vld),
        .wr_en   (fill_wr),
        .wr_idx  (st_q.fb_line[IDX_W-1:0]),
        .wr_tag  (st_q.fb_line[LADDR_W-1:IDX_W])
    );

    for (genvar b = 0; b < LINE_WORDS; b++) begin : g_bank
        icache_data_bank #(
            .DEPTH (LINES),
            .WIDTH (DATA_W)
        ) i_bank (
            .clk     (clk),
            .rd_idx  (f_idx),
            .rd_data (bank_rd[b]),
            .wr_en   (fill_wr),
            .wr_idx  (st_q.fb_line[IDX_W-1:0]),
            .wr_data (st_q.fb_data[b])
        );
    end

    logic arr_hit, fb_hit, active, hit, line_done, miss_go;

    always_comb begin
        st_d      = st_q;
        st_d.req  = 1'b0;

        arr_hit   = arr_vld && (arr_tag == f_tag);
        fb_hit    = (st_q.fb_line == f_line) && st_q.fb_vld[f_off];
        active    = fetch_req && !sram_sel && !flush;
        hit       = active && (arr_hit || fb_hit);
        line_done = st_q.busy && (st_q.beats == CNT_W'(LINE_WORDS));
        fill_wr   = line_done && !st_q.kill && !flush;
        miss_go   = active && !hit && !st_q.busy;

        // capture burst beats in wrap order
        if (st_q.busy && mem_rvalid && !line_done) begin
            if (!st_q.kill) begin
                st_d.fb_data[st_q.beat_off] = mem_rdata;
                st_d.fb_vld[st_q.beat_off]  = 1'b1;
            end
            st_d.beat_off = st_q.beat_off + 1'b1;
            st_d.beats    = st_q.beats + 1'b1;
        end

        if (line_done) begin
            st_d.busy = 1'b0;
            st_d.kill = 1'b0;
        end

        if (miss_go) begin
            st_d.busy     = 1'b1;
            st_d.kill     = 1'b0;
            st_d.req      = 1'b1;
            st_d.req_addr = {fetch_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
            st_d.fb_line  = f_line;
            st_d.fb_vld   = '0;
            st_d.beat_off = f_off;
            st_d.beats    = '0;
        end

        if (flush) begin
            st_d.fb_vld = '0;
            if (st_q.busy && !line_done) st_d.kill = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cache_ready = hit;
    assign fetch_rdata = !hit    ? '0 :
                         fb_hit  ? st_q.fb_data[f_off] : bank_rd[f_off];
    assign mem_req     = st_q.req;
    assign mem_addr    = st_q.req_addr;
endmodule

// File: rtl/icache_chk.sv
`timescale 1ns/1ps
module icache_chk #(
    parameter int LINE_WORDS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic fetch_req,
    input logic sram_sel,
    input logic flush,
    input logic cache_ready,
    input logic mem_req,
    input logic mem_rvalid
);
    localparam int CNT_W = $clog2(LINE_WORDS) + 1;

    logic             pend_q;
    logic [CNT_W-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            seen_q <= '0;
        end else if (mem_req) begin
            pend_q <= 1'b1;
            seen_q <= '0;
        end else if (pend_q && mem_rvalid) begin
            seen_q <= seen_q + 1'b1;
            if (seen_q == CNT_W'(LINE_WORDS - 1)) pend_q <= 1'b0;
        end
    end

    // R2
    ready_has_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_ready |-> fetch_req);
    // R4
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R7
    one_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !pend_q);
    // R9
    sram_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && sram_sel) |-> !cache_ready);
    // R9
    sram_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && sram_sel) |=> !mem_req);
    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !cache_ready);
endmodule

bind icache_top icache_chk #(.LINE_WORDS(LINE_WORDS)) u_icache_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req),
    .sram_sel    (sram_sel),
    .flush       (flush),
    .cache_ready (cache_ready),
    .mem_req     (mem_req),
    .mem_rvalid  (mem_rvalid)
);

// File: tb/test_icache_top.sv
`timescale 1ns/1ps
module test_icache_top;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        sram_sel = 1'b0;
    logic        flush = 1'b0;
    logic        cache_ready;
    logic [31:0] fetch_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    int req_count;
    logic [31:0] last_req;

    always #4 clk = ~clk;

    icache_top i_icache_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .sram_sel    (sram_sel),
        .flush       (flush),
        .cache_ready (cache_ready),
        .fetch_rdata (fetch_rdata),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata)
    );

    function automatic logic [31:0] mdata(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h3C5A_96E1;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // present a fetch, hold it until served; cyc = cycles waited
    task automatic run_fetch(input logic [31:0] a, output int cyc, output logic [31:0] d);
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = a;
        cyc = 0;
        d   = '0;
        forever begin
            #2;
            if (cache_ready) begin
                d = fetch_rdata;
                break;
            end
            cyc++;
            if (cyc > 60) break;
            @(negedge clk);
        end
        @(negedge clk);
        fetch_req = 1'b0;
    endtask

    // external memory: fixed latency, wrapped four-beat burst
    initial begin
        logic [31:0] base;
        logic [1:0]  off;
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        req_count  = 0;
        last_req   = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                req_count++;
                last_req = mem_addr;
                base     = mem_addr;
                repeat (LAT) @(negedge clk);
                for (int k = 0; k < 4; k++) begin
                    off        = base[3:2] + 2'(k);
                    mem_rvalid = 1'b1;
                    mem_rdata  = mdata({base[31:4], off, 2'b00});
                    @(negedge clk);
                end
                mem_rvalid = 1'b0;
            end
        end
    end

    // {expect immediate hit, address}
    localparam logic [32:0] VEC [8] = '{
        {1'b0, 32'h0000_1000},   // R1 cold miss
        {1'b1, 32'h0000_1004},   // R2 same line
        {1'b1, 32'h0000_100C},   // R2
        {1'b0, 32'h0000_2000},   // line index 0
        {1'b0, 32'h0000_3000},   // R3 same index as 0x1000, other tag
        {1'b0, 32'h0000_1008},   // R3 evicted
        {1'b1, 32'h0000_2004},   // R8 from arrays, buffer holds another line
        {1'b0, 32'h0000_3008}    // R3 evicted again
    };

    initial begin
        int          cyc;
        int          r0;
        logic [31:0] d;

        // R1 reset state
        repeat (3) @(negedge clk);
        #2;
        check(mem_req == 1'b0, "R1 mem_req at reset", 32'(mem_req), 32'd0);
        check(cache_ready == 1'b0, "R1 ready at reset", 32'(cache_ready), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            logic [31:0] a;
            logic        eh;
            a  = VEC[i][31:0];
            eh = VEC[i][32];
            r0 = req_count;
            run_fetch(a, cyc, d);
            if (eh) begin
                check(cyc == 0, "R2 hit latency", 32'(cyc), 32'd0);
                check(req_count == r0, "R2 no request", 32'(req_count), 32'(r0));
            end else begin
                check(cyc == 4, "R4 miss latency", 32'(cyc), 32'd4);
                check(req_count == r0 + 1, "R4 one request", 32'(req_count), 32'(r0 + 1));
                check(last_req == a, "R4 mem_addr", last_req, a);
            end
            check(d == mdata(a), eh ? "R2 data" : "R4 data", d, mdata(a));
            repeat (10) @(negedge clk);
        end

        // R5 critical word first, then a late word of the same line
        r0 = req_count;
        run_fetch(32'h0000_4108, cyc, d);
        check(cyc == 4, "R5 critical word latency", 32'(cyc), 32'd4);
        check(d == mdata(32'h4108), "R5 critical data", d, mdata(32'h4108));
        run_fetch(32'h0000_4104, cyc, d);
        check(cyc == 1, "R5 waits for own beat", 32'(cyc), 32'd1);
        check(d == mdata(32'h4104), "R5 last beat data", d, mdata(32'h4104));
        check(req_count == r0 + 1, "R5 no extra request", 32'(req_count), 32'(r0 + 1));
        repeat (10) @(negedge clk);

        // R6 array hit during an outstanding fill
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = 32'h0000_5200;
        @(negedge clk);
        fetch_addr = 32'h0000_2004;
        #2;
        check(mem_req == 1'b1, "R6 fill outstanding", 32'(mem_req), 32'd1);
        check(cache_ready == 1'b1, "R6 hit during fill", 32'(cache_ready), 32'd1);
        check(fetch_rdata == mdata(32'h2004), "R6 data", fetch_rdata, mdata(32'h2004));
        @(negedge clk);
        fetch_req = 1'b0;
        repeat (12) @(negedge clk);

        // R7 second miss stalls behind the first fill
        r0 = req_count;
        fetch_req  = 1'b1;
        fetch_addr = 32'h0000_6300;
        @(negedge clk);
        fetch_addr = 32'h0000_7400;
        for (int k = 0; k < 4; k++) begin
            #2;
            check(cache_ready == 1'b0, "R7 stalled", 32'(cache_ready), 32'd0);
            @(negedge clk);
        end
        check(req_count == r0 + 1, "R7 single request", 32'(req_count), 32'(r0 + 1));
        cyc = 0;
        forever begin
            #2;
            if (cache_ready || cyc > 60) break;
            cyc++;
            @(negedge clk);
        end
        check(cache_ready == 1'b1, "R7 eventually served", 32'(cache_ready), 32'd1);
        check(fetch_rdata == mdata(32'h7400), "R7 data", fetch_rdata, mdata(32'h7400));
        check(req_count == r0 + 2, "R7 second request", 32'(req_count), 32'(r0 + 2));
        @(negedge clk);
        fetch_req = 1'b0;
        repeat (12) @(negedge clk);
        // R8 first stalled line was written
        r0 = req_count;
        run_fetch(32'h0000_6304, cyc, d);
        check(cyc == 0, "R8 written line hits", 32'(cyc), 32'd0);

        // R9 SRAM-mapped fetches
        repeat (4) @(negedge clk);
        r0 = req_count;
        fetch_req  = 1'b1;
        sram_sel   = 1'b1;
        fetch_addr = 32'h0000_2004;
        #2;
        check(cache_ready == 1'b0, "R9 hit suppressed", 32'(cache_ready), 32'd0);
        @(negedge clk);
        fetch_addr = 32'h0000_9000;
        repeat (6) @(negedge clk);
        check(req_count == r0, "R9 no request", 32'(req_count), 32'(r0));
        fetch_req = 1'b0;
        sram_sel  = 1'b0;
        repeat (4) @(negedge clk);

        // R10 flush while idle
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        r0 = req_count;
        run_fetch(32'h0000_2004, cyc, d);
        check(cyc == 4, "R10 flushed line misses", 32'(cyc), 32'd4);
        check(req_count == r0 + 1, "R10 refetch request", 32'(req_count), 32'(r0 + 1));
        repeat (10) @(negedge clk);

        // R10 flush during a fill
        fetch_req  = 1'b1;
        fetch_addr = 32'h0000_A000;
        @(negedge clk);
        fetch_req = 1'b0;
        flush     = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        repeat (12) @(negedge clk);
        r0 = req_count;
        run_fetch(32'h0000_A004, cyc, d);
        check(cyc == 4, "R10 killed fill not written", 32'(cyc), 32'd4);
        check(d == mdata(32'hA004), "R10 data", d, mdata(32'hA004));
        repeat (10) @(negedge clk);

        // R1 reset clears valid lines
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        r0 = req_count;
        run_fetch(32'h0000_A004, cyc, d);
        check(cyc == 4, "R1 miss after reset", 32'(cyc), 32'd4);
        check(req_count == r0 + 1, "R1 request after reset", 32'(req_count), 32'(r0 + 1));
        repeat (8) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule